// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the register file of a simple LCD controller, placed on a 32-bit register bus. It holds six word-aligned registers: control, three timing words, a read-only status word and a subpanel word. It decodes the control and timing writes into configuration fields for the rest of the controller: enable, mono, TFT, palette-load mode, panel width and panel height. Reads return the stored fields, with fixed constant patterns ORed into several of the words.

The block also keeps three sticky status flags: frame done, palette loaded and sync error. A fetch engine sets them through one-cycle event inputs. A level interrupt output combines the flags. Frame done and palette loaded each need their own enable bit. Sync error raises the interrupt with no enable. Turning the controller off or on through the control enable bit also changes the flags as a side effect.

Top module: `lcdr_regs`

## Requirements
- R1: A write to byte offset 0x00 captures enable from bit 0, mono from bit 1, interrupt enables from bits 4:3 (bit 3 gates frame done, bit 4 gates palette loaded), TFT from bit 7, palette-load mode from bits 21:20, and an opaque field `wdata & 0x01CFF300`. A read of 0x00 returns `opaque | tft<<23 | mode<<20 | tft<<7 | ie<<3 | mono<<1 | enable | 0xFE000C34`.
- R2: A write to 0x04 stores bits 31:10 and sets width to bits 9:0 plus one. A read of 0x04 returns `field<<10 | ((width-1) & 0x3FF) | 0xF`. Output `cfg_width` shows the width.
- R3: A write to 0x08 stores bits 31:10 and sets height to bits 9:0 plus one. A read of 0x08 returns `field<<10 | ((height-1) & 0x3FF)`. Output `cfg_height` shows the height.
- R4: A write to 0x0C stores the full word. A read of 0x0C returns it ORed with 0xFC000000.
- R5: A write to 0x14 stores `wdata & 0xA1FFFFFF`. A read of 0x14 returns the stored value.
- R6: A read of 0x10 returns frame done at bit 0, sync error at bit 2 and palette loaded at bit 6, with all other bits zero. Writes to 0x10 change nothing.
- R7: A one-cycle pulse on `ev_frame`, `ev_palette` or `ev_sync` sets its flag from the next cycle. The flag stays set until an enable transition clears it.
- R8: `irq` is high exactly when (frame done and ie bit 0) or (palette loaded and ie bit 1) or sync error.
- R9: A control write that changes enable from 1 to 0 clears sync error. The same write sets frame done unless the written mode equals 1. These effects take priority over events in the same cycle.
- R10: A control write that changes enable from 0 to 1 clears frame done and palette loaded. This takes priority over events in the same cycle.
- R11: After reset, all configuration fields, the width, the height, the subpanel word and all flags are zero. The timing reads therefore give 0x3FF.
- R12: Any offset other than the six registers, including misaligned ones, reads as zero and ignores writes. Such an access raises `bus_err` for one cycle, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one per cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| bus_err | output | 1 | Unmapped-access pulse |
| ev_palette | input | 1 | Palette-loaded event |
| ev_frame | input | 1 | Frame-done event |
| ev_sync | input | 1 | Sync-error event |
| irq | output | 1 | Level interrupt |
| cfg_enable | output | 1 | Controller enable |
| cfg_mono | output | 1 | Mono flag |
| cfg_tft | output | 1 | TFT flag |
| cfg_plmode | output | 2 | Palette-load mode |
| cfg_width | output | DIM_W+1 | Panel width |
| cfg_height | output | DIM_W+1 | Panel height |

## Verification
The bench builds the block with its default parameters: ADDR_W of 8 and DIM_W of 10. With an 8-bit offset, it can sweep every byte offset, so each unmapped and misaligned address is checked for a zero read and an error pulse. With 10-bit dimensions, the width and height fields can be stepped across their range, including both ends. It also walks a single one through every bit of the control and subpanel words, and it covers all 32 combinations of the three flags and two interrupt enables.

// File: rtl/lcdr_pkg.sv
// Shared constants for the LCD register block: register offsets and the
// read and write masks whose bit positions software relies on.
package lcdr_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OFF_CTRL   = 'h00;
    localparam int unsigned OFF_TIM0   = 'h04;
    localparam int unsigned OFF_TIM1   = 'h08;
    localparam int unsigned OFF_TIM2   = 'h0C;
    localparam int unsigned OFF_STAT   = 'h10;
    localparam int unsigned OFF_SUB    = 'h14;
    localparam logic [31:0] CTRL_KEEP  = 32'h01CF_F300;
    localparam logic [31:0] CTRL_ONES  = 32'hFE00_0C34;
    localparam logic [31:0] TIM0_ONES  = 32'h0000_000F;
    localparam logic [31:0] TIM2_ONES  = 32'hFC00_0000;
    localparam logic [31:0] SUB_KEEP   = 32'hA1FF_FFFF;
    localparam int unsigned PLM_LSB    = 20;
    localparam logic [1:0]  PLM_NOLOAD = 2'd1;
endpackage

// File: rtl/lcdr_cfg.sv
// Configuration storage. Captures the control, timing and subpanel
// writes and decodes their fields. It also reports the enable
// transitions that a control write causes.
// Assumes: the write strobes are one-hot and already qualified by the
// access strobe.
module lcdr_cfg
    import lcdr_pkg::*;
#(
    parameter int unsigned DIM_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_tim0,
    input  logic                 wr_tim1,
    input  logic                 wr_tim2,
    input  logic                 wr_sub,
    input  logic [WORD_W-1:0]    wdata,
    output logic                 en_q,
    output logic                 mono_q,
    output logic                 tft_q,
    output logic [1:0]           plm_q,
    output logic [1:0]           ie_q,
    output logic [WORD_W-1:0]    opaque_q,
    output logic [WORD_W-DIM_W-1:0] tim0_q,
    output logic [WORD_W-DIM_W-1:0] tim1_q,
    output logic [WORD_W-1:0]    tim2_q,
    output logic [WORD_W-1:0]    sub_q,
    output logic [DIM_W:0]       width_q,
    output logic [DIM_W:0]       height_q,
    output logic                 en_rise,
    output logic                 en_fall
);
    localparam int unsigned TF_W = WORD_W - DIM_W;

    // Enable transitions caused by the control write in this cycle.
    always_comb begin
        en_rise = wr_ctrl &&  wdata[0] && !en_q;
        en_fall = wr_ctrl && !wdata[0] &&  en_q;
    end

    // Control word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mono_q   <= 1'b0;
            tft_q    <= 1'b0;
            plm_q    <= 2'd0;
            ie_q     <= 2'd0;
            opaque_q <= '0;
        end else if (wr_ctrl) begin
            en_q     <= wdata[0];
            mono_q   <= wdata[1];
            ie_q     <= wdata[4:3];
            tft_q    <= wdata[7];
            plm_q    <= wdata[PLM_LSB +: 2];
            opaque_q <= wdata & CTRL_KEEP;
        end
    end

    // Timing words and panel dimensions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim0_q   <= '0;
            tim1_q   <= '0;
            tim2_q   <= '0;
            width_q  <= '0;
            height_q <= '0;
        end else begin
            if (wr_tim0) begin
                tim0_q  <= wdata[WORD_W-1:DIM_W];
                width_q <= {1'b0, wdata[DIM_W-1:0]} + 1'b1;
            end
            if (wr_tim1) begin
                tim1_q   <= wdata[WORD_W-1:DIM_W];
                height_q <= {1'b0, wdata[DIM_W-1:0]} + 1'b1;
            end
            if (wr_tim2) begin
                tim2_q <= wdata;
            end
        end
    end

    // Subpanel word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= '0;
        else if (wr_sub) sub_q <= wdata & SUB_KEEP;
    end

    AST_WIDTH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tim0 |=> width_q == ({1'b0, $past(wdata[DIM_W-1:0])} + 1'b1)); // R2
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> en_q); // R10

    logic unused_tf;
    assign unused_tf = ^TF_W;
endmodule

// File: rtl/lcdr_stat.sv
// Status flags and interrupt. Keeps the sticky frame-done,
// palette-loaded and sync-error flags and drives the level interrupt.
// Assumes: the events are one-cycle pulses. Enable transitions override
// events that arrive in the same cycle.
module lcdr_stat
    import lcdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_palette,
    input  logic       ev_frame,
    input  logic       ev_sync,
    input  logic       en_rise,
    input  logic       en_fall,
    input  logic [1:0] new_mode,
    input  logic [1:0] ie,
    output logic       frame_q,
    output logic       pal_q,
    output logic       sync_q,
    output logic       irq
);
    logic frame_n, pal_n, sync_n;

    // Next flag values: events set the flags, then enable transitions override.
    always_comb begin
        frame_n = frame_q | ev_frame;
        pal_n   = pal_q   | ev_palette;
        sync_n  = sync_q  | ev_sync;
        if (en_rise) begin
            frame_n = 1'b0;
            pal_n   = 1'b0;
        end
        if (en_fall) begin
            sync_n = 1'b0;
            if (new_mode != PLM_NOLOAD) frame_n = 1'b1;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            pal_q   <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            frame_q <= frame_n;
            pal_q   <= pal_n;
            sync_q  <= sync_n;
        end
    end

    // Level interrupt.
    always_comb irq = (frame_q & ie[0]) | (pal_q & ie[1]) | sync_q;

    AST_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !sync_q); // R9
    AST_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall && new_mode != PLM_NOLOAD |=> frame_q); // R9
    AST_RISE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !frame_q && !pal_q); // R10
    AST_SYNC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync && !en_fall |=> irq); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q && !en_rise |=> frame_q); // R7
endmodule

// File: rtl/lcdr_regs.sv
// LCD register block top. Decodes the byte offset, routes writes to
// the configuration and status submodules, builds the read word and
// flags unmapped accesses.
// Assumes: at most one access per cycle, with reads combinational from
// the offset.
module lcdr_regs
    import lcdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIM_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic               ev_palette,
    input  logic               ev_frame,
    input  logic               ev_sync,
    output logic               irq,
    output logic               cfg_enable,
    output logic               cfg_mono,
    output logic               cfg_tft,
    output logic [1:0]         cfg_plmode,
    output logic [DIM_W:0]     cfg_width,
    output logic [DIM_W:0]     cfg_height
);
    localparam int unsigned TF_W = WORD_W - DIM_W;

    logic hit_ctrl, hit_tim0, hit_tim1, hit_tim2, hit_stat, hit_sub, hit_any;
    logic wr_en;
    logic [1:0]           ie_q;
    logic [WORD_W-1:0]    opaque_q, tim2_q, sub_q;
    logic [TF_W-1:0]      tim0_q, tim1_q;
    logic [DIM_W:0]       width_m1, height_m1;
    logic                 en_rise, en_fall;
    logic                 frame_q, pal_q, sync_q;

    // Offset decode.
    always_comb begin
        hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
        hit_tim0 = bus_addr == ADDR_W'(OFF_TIM0);
        hit_tim1 = bus_addr == ADDR_W'(OFF_TIM1);
        hit_tim2 = bus_addr == ADDR_W'(OFF_TIM2);
        hit_stat = bus_addr == ADDR_W'(OFF_STAT);
        hit_sub  = bus_addr == ADDR_W'(OFF_SUB);
        hit_any  = hit_ctrl | hit_tim0 | hit_tim1 | hit_tim2 | hit_stat | hit_sub;
        wr_en    = bus_valid & bus_wr;
    end

    lcdr_cfg #(.DIM_W(DIM_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_en & hit_ctrl),
        .wr_tim0  (wr_en & hit_tim0),
        .wr_tim1  (wr_en & hit_tim1),
        .wr_tim2  (wr_en & hit_tim2),
        .wr_sub   (wr_en & hit_sub),
        .wdata    (bus_wdata),
        .en_q     (cfg_enable),
        .mono_q   (cfg_mono),
        .tft_q    (cfg_tft),
        .plm_q    (cfg_plmode),
        .ie_q     (ie_q),
        .opaque_q (opaque_q),
        .tim0_q   (tim0_q),
        .tim1_q   (tim1_q),
        .tim2_q   (tim2_q),
        .sub_q    (sub_q),
        .width_q  (cfg_width),
        .height_q (cfg_height),
        .en_rise  (en_rise),
        .en_fall  (en_fall)
    );

    lcdr_stat i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_palette (ev_palette),
        .ev_frame   (ev_frame),
        .ev_sync    (ev_sync),
        .en_rise    (en_rise),
        .en_fall    (en_fall),
        .new_mode   (bus_wdata[PLM_LSB +: 2]),
        .ie         (ie_q),
        .frame_q    (frame_q),
        .pal_q      (pal_q),
        .sync_q     (sync_q),
        .irq        (irq)
    );

    // Read word assembly.
    always_comb begin
        width_m1  = cfg_width  - 1'b1;
        height_m1 = cfg_height - 1'b1;
        bus_rdata = '0;
        if (hit_ctrl)
            bus_rdata = opaque_q | CTRL_ONES |
                        {8'b0, cfg_tft, 1'b0, cfg_plmode, 12'b0,
                         cfg_tft, 2'b0, ie_q, 1'b0, cfg_mono, cfg_enable};
        if (hit_tim0)
            bus_rdata = {tim0_q, width_m1[DIM_W-1:0]} | TIM0_ONES;
        if (hit_tim1)
            bus_rdata = {tim1_q, height_m1[DIM_W-1:0]};
        if (hit_tim2)
            bus_rdata = tim2_q | TIM2_ONES;
        if (hit_stat)
            bus_rdata = {25'b0, pal_q, 3'b0, sync_q, 1'b0, frame_q};
        if (hit_sub)
            bus_rdata = sub_q;
    end

    // Unmapped access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bus_valid & ~hit_any;
    end

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid)); // R12
    AST_STAT_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && hit_stat && !ev_frame && !ev_palette && !ev_sync
        |=> $stable({frame_q, pal_q, sync_q})); // R6
endmodule

// File: tb/test_lcdr_regs.sv
module test_lcdr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ev_palette = 1'b0, ev_frame = 1'b0, ev_sync = 1'b0;
    logic        irq, cfg_enable, cfg_mono, cfg_tft;
    logic [1:0]  cfg_plmode;
    logic [10:0] cfg_width, cfg_height;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;
    logic        last_err;

    lcdr_regs i_lcdr_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .ev_palette(ev_palette), .ev_frame(ev_frame),
        .ev_sync(ev_sync), .irq(irq), .cfg_enable(cfg_enable),
        .cfg_mono(cfg_mono), .cfg_tft(cfg_tft), .cfg_plmode(cfg_plmode),
        .cfg_width(cfg_width), .cfg_height(cfg_height)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        last_err = bus_err;
        bus_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        last_err = bus_err;
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input logic f, input logic p, input logic s);
        @(negedge clk);
        ev_frame = f; ev_palette = p; ev_sync = s;
        @(posedge clk); #1;
        ev_frame = 1'b0; ev_palette = 1'b0; ev_sync = 1'b0;
    endtask

    // Clear all flags: rise, fall with mode 1, rise; leaves enable on.
    task automatic clear_flags();
        wr(8'h00, 32'h0000_0001);
        wr(8'h00, 32'h0010_0000);
        wr(8'h00, 32'h0000_0001);
    endtask

    function automatic logic [31:0] ctrl_exp(input logic [31:0] v);
        return (v & 32'h01CF_F300) | 32'hFE00_0C34 | (32'(v[7]) << 23) |
               (32'(v[21:20]) << 20) | (32'(v[7]) << 7) | (32'(v[4:3]) << 3) |
               (32'(v[1]) << 1) | 32'(v[0]);
    endfunction

    initial begin
        logic [31:0] snap [6];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        rd(8'h00, rv); check("R11 ctrl", rv, 32'hFE00_0C34);
        rd(8'h04, rv); check("R11 tim0", rv, 32'h0000_03FF);
        rd(8'h08, rv); check("R11 tim1", rv, 32'h0000_03FF);
        rd(8'h0C, rv); check("R11 tim2", rv, 32'hFC00_0000);
        rd(8'h10, rv); check("R11 stat", rv, 32'h0);
        rd(8'h14, rv); check("R11 sub", rv, 32'h0);
        check("R11 irq", 32'(irq), 32'h0);
        check("R11 width", 32'(cfg_width), 32'h0);

        // R1 walking one through the control word
        for (int b = 0; b < 32; b++) begin
            wr(8'h00, 32'h1 << b);
            rd(8'h00, rv); check("R1 ctrl walk", rv, ctrl_exp(32'h1 << b));
        end
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, rv); check("R1 ctrl ones", rv, ctrl_exp(32'hFFFF_FFFF));
        check("R1 fields", {27'b0, cfg_enable, cfg_mono, cfg_tft, cfg_plmode}, 32'h1F);

        // R2 R3 dimension sweep
        for (int w = 0; w < 1024; w += 31) begin
            wr(8'h04, 32'hABCD_0000 | 32'(w));
            rd(8'h04, rv);
            check("R2 tim0", rv, (32'hABCD_0000 & 32'hFFFF_FC00) | 32'(w) | 32'hF);
            check("R2 width", 32'(cfg_width), 32'(w + 1));
            wr(8'h08, 32'h1234_5400 | 32'(1023 - w));
            rd(8'h08, rv);
            check("R3 tim1", rv, 32'h1234_5400 | 32'(1023 - w));
            check("R3 height", 32'(cfg_height), 32'(1024 - w));
        end
        wr(8'h04, 32'h0000_03FF); check("R2 width max", 32'(cfg_width), 32'd1024);
        rd(8'h04, rv); check("R2 tim0 max", rv, 32'h0000_03FF);

        // R4 R5 walking one
        for (int b = 0; b < 32; b++) begin
            wr(8'h0C, 32'h1 << b);
            rd(8'h0C, rv); check("R4 tim2", rv, (32'h1 << b) | 32'hFC00_0000);
            wr(8'h14, 32'h1 << b);
            rd(8'h14, rv); check("R5 sub", rv, (32'h1 << b) & 32'hA1FF_FFFF);
        end

        // R6 R7 R8 flags against interrupt enables
        for (int c = 0; c < 32; c++) begin
            logic f, p, s;
            logic [1:0] ie;
            f = c[0]; p = c[1]; s = c[2]; ie = c[4:3];
            clear_flags();
            pulse(f, p, s);
            wr(8'h00, (32'(ie) << 3) | 32'h1);
            rd(8'h10, rv);
            check("R7 stat", rv, (32'(p) << 6) | (32'(s) << 2) | 32'(f));
            check("R8 irq", 32'(irq), 32'((f & ie[0]) | (p & ie[1]) | s));
            wr(8'h10, 32'h0000_0000);
            rd(8'h10, rv);
            check("R6 stat write ignored", rv, (32'(p) << 6) | (32'(s) << 2) | 32'(f));
        end

        // R9 disable side effects for every mode
        for (int m = 0; m < 4; m++) begin
            clear_flags();
            pulse(1'b0, 1'b1, 1'b1);
            wr(8'h00, 32'(m) << 20);
            rd(8'h10, rv);
            check("R9 disable", rv, 32'h40 | ((m == 1) ? 32'h0 : 32'h1));
        end
        // R9 disable overrides a same-cycle sync event
        clear_flags();
        @(negedge clk);
        bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
        ev_sync = 1'b1;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_wr = 1'b0; ev_sync = 1'b0;
        rd(8'h10, rv); check("R9 override", rv, 32'h1);

        // R10 enable clears frame and palette, not sync
        pulse(1'b1, 1'b1, 1'b1);
        wr(8'h00, 32'h1);
        rd(8'h10, rv); check("R10 enable", rv, 32'h4);
        // no transition: writing enable again keeps flags
        pulse(1'b1, 1'b0, 1'b0);
        wr(8'h00, 32'h1);
        rd(8'h10, rv); check("R10 no edge", rv, 32'h5);

        // R12 unmapped offsets
        for (int r = 0; r < 6; r++) rd(8'(r * 4), snap[r]);
        for (int a = 0; a < 256; a++) begin
            if (a[1:0] == 2'b00 && a < 24) continue;
            rd(8'(a), rv);
            check("R12 read zero", rv, 32'h0);
            check("R12 err", 32'(last_err), 32'h1);
            wr(8'(a), 32'hFFFF_FFFF);
            check("R12 wr err", 32'(last_err), 32'h1);
        end
        for (int r = 0; r < 6; r++) begin
            rd(8'(r * 4), rv);
            check("R12 no effect", rv, snap[r]);
            check("R12 mapped no err", 32'(last_err), 32'h0);
        end
        @(posedge clk); #1;
        check("R12 pulse ends", 32'(bus_err), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule